// File: doc/BRIEF.md
# RF Frame Exchange Buffer

This block holds one frame at a time for a contactless reader. The same 36-byte store carries the outgoing request and, after the exchange, the incoming answer. The host fills it through a sequential byte port: it restarts the pointer, writes a length byte, and then writes the payload. A start strobe streams the payload to the transmitter and follows it with a 16-bit CRC. The block then wipes the store and waits for a reply under a timeout chosen by the host.

The receiver delivers the answer as a byte stream, with its two CRC bytes last, and then strobes `rx_done`. The block checks the CRC itself. It keeps the payload and writes the outcome into byte 0: the payload length, 00h when the timeout expires first, or FFh when the answer is malformed. The host reads the result back from byte 0 upward. Modulation, bit coding and the serial host bus are outside this block.

Top module: `rf_frame_buffer`

## Requirements
- R1: After reset, busy, len_err and tx_valid are 0, all 36 bytes read 00h, and the pointer is at byte 0.
- R2: While idle, host_restart sets the pointer to 0. Each host_wr_en stores host_wr_data at the pointer, and each host_wr_en or host_rd_en advances the pointer by one. host_rd_data shows the byte at the pointer. The pointer holds at byte 35 once it gets there.
- R3: A start strobe with byte 0 in the range 1..35 sends bytes 1..L on tx_data, in order, using a valid/ready handshake (L is the value of byte 0). While tx_ready is low, tx_valid stays high and tx_data does not change.
- R4: Two more bytes follow the payload. They are the CRC-16 over the payload, computed with reflected polynomial 8408h and preset FFFFh. The CRC is ones-complemented and sent low byte first.
- R5: Once the second CRC byte has been taken, all 36 bytes are cleared to 00h before reception begins.
- R6: During the wait, the answer arrives as N data bytes followed by their two CRC bytes, and then an rx_done strobe. If the CRC matches and N is in 1..35, bytes 1..N hold the data, byte 0 holds N, the CRC bytes are not stored, busy falls, and the pointer returns to 0.
- R7: Byte 0 becomes FFh and bytes 1..35 read 00h in three cases: a CRC mismatch, fewer than 3 received bytes, or more than 37 received bytes.
- R8: The wait lasts 500, 5000, 10000 or 309000 microseconds for wdg_sel 00, 01, 10 and 11, with CYC_PER_US cycles per microsecond. If no rx_done arrives in that window, every byte reads 00h. Busy is then high for exactly L+3+limit cycles when tx_ready stays high.
- R9: A start with byte 0 equal to 0 or greater than 35 sets len_err. In that case nothing is transmitted and busy stays low. The next accepted start clears len_err.
- R10: Busy is high from an accepted start until the answer or the timeout. While busy, host writes, reads and restarts have no effect. Received bytes and rx_done are ignored outside the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_restart | input | 1 | Return host pointer to byte 0 |
| host_wr_en | input | 1 | Write host_wr_data at pointer, then advance |
| host_wr_data | input | 8 | Host write byte |
| host_rd_en | input | 1 | Advance pointer after a read |
| host_rd_data | output | 8 | Byte at the host pointer |
| start | input | 1 | Begin an exchange |
| wdg_sel | input | 2 | Answer timeout select, latched at start |
| busy | output | 1 | Exchange in progress |
| len_err | output | 1 | Last start rejected for a bad length |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_done | input | 1 | End of answer, given after the last byte |

## Verification
The transmit path is tested with payload lengths 1, 2, 7 and 35. Some runs hold tx_ready high and others stall it with a pseudo-random pattern. The stalled runs separate handshake bugs from CRC-order bugs. The answer path is fed the following:
- good answers at the length boundaries;
- a single corrupted data byte;
- a CRC-only stream;
- a stream one byte too long.

Together these tell length accounting apart from CRC checking. Timeouts are measured as exact busy durations for three selects. The longest select is shown to still accept a late answer, which proves the select is decoded rather than defaulted. Lengths 0, 36 and 200 are presented at start, and host and receiver traffic arrives outside its window; both confirm that nothing leaks into the store.

// File: rtl/rfb_pkg.sv
// Shared types and the CRC step for the frame exchange buffer.
// Assumes byte-wide data and the reflected CRC-16 used on the contactless link.
package rfb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_DATA,
        ST_TX_CRC_LO,
        ST_TX_CRC_HI,
        ST_CLEAR,
        ST_WAIT
    } rfb_state_t;

    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;

    // Advance the reflected CRC-16 by one byte, LSB first.
    function automatic logic [15:0] crc16b_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rfb_watchdog.sv
// Answer timeout counter. It is armed for one cycle, then runs until it is
// stopped or until its limit is reached. The limit is picked by sel from four
// microsecond values scaled by CYC_PER_US. sel must stay stable while it runs.
module rfb_watchdog #(
    parameter int unsigned CYC_PER_US = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       stop,
    input  logic [1:0] sel,
    output logic       running,
    output logic       expired
);
    localparam int unsigned LIM0 = 500 * CYC_PER_US;
    localparam int unsigned LIM1 = 5000 * CYC_PER_US;
    localparam int unsigned LIM2 = 10000 * CYC_PER_US;
    localparam int unsigned LIM3 = 309000 * CYC_PER_US;
    localparam int unsigned CW   = $clog2(LIM3 + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Pick the final count value for the selected timeout.
    always_comb begin
        case (sel)
            2'b00:   last = CW'(LIM0 - 1);
            2'b01:   last = CW'(LIM1 - 1);
            2'b10:   last = CW'(LIM2 - 1);
            default: last = CW'(LIM3 - 1);
        endcase
    end

    assign expired = running && (cnt == last);

    // Count wait cycles from arming until stop or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (arm) begin
            cnt     <= '0;
            running <= 1'b1;
        end else if (running) begin
            if (stop || expired) begin
                running <= 1'b0;
            end
            cnt <= cnt + 1'b1;
        end
    end

    // R8: the counter never runs past the selected limit
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= last));
    // R8: arming restarts the count from zero
    a_r8_arm_restart: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (running && cnt == '0));

endmodule

// File: rtl/rfb_rx_stage.sv
// Receive staging. It holds the two newest bytes back, so the trailing CRC
// pair is never pushed into the buffer. Each older byte is forwarded as
// payload to buffer index 1 upward, and the CRC is accumulated over those
// bytes. After rx_done it reports whether the answer is well formed.
// Assumes rx_done never coincides with a received byte.
module rfb_rx_stage
    import rfb_pkg::*;
#(
    parameter int unsigned MAX_PAY = 35,
    parameter int unsigned PW      = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    output logic          push_valid,
    output logic [PW-1:0] push_idx,
    output logic [7:0]    push_data,
    output logic          ans_good,
    output logic [7:0]    ans_len
);
    localparam int unsigned CW = $clog2(MAX_PAY + 4);

    logic [CW-1:0] cnt;
    logic [7:0]    hold_old;
    logic [7:0]    hold_new;
    logic [15:0]   crc;
    logic          take;
    logic          spill;

    assign take       = en && rx_valid;
    assign spill      = take && (cnt >= CW'(2));
    assign push_valid = spill && (cnt <= CW'(MAX_PAY + 1));
    assign push_idx   = PW'(cnt - CW'(1));
    assign push_data  = hold_old;
    assign ans_len    = 8'(cnt - CW'(2));
    assign ans_good   = (cnt >= CW'(3)) && (cnt <= CW'(MAX_PAY + 2))
                        && (hold_old == ~crc[7:0]) && (hold_new == ~crc[15:8]);

    // Shift bytes through the two-deep hold, count them, and accumulate the CRC.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt      <= '0;
            hold_old <= 8'h00;
            hold_new <= 8'h00;
            crc      <= CRC_PRESET;
        end else if (take) begin
            hold_old <= hold_new;
            hold_new <= rx_data;
            if (cnt != '1) begin
                cnt <= cnt + 1'b1;
            end
            if (spill) begin
                crc <= crc16b_step(crc, hold_old);
            end
        end
    end

    // R10: without enable, the byte count does not move
    a_r10_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clear) |=> $stable(cnt));
    // R6: payload bytes only land inside the buffer's data area
    a_r6_push_range: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> (push_idx >= PW'(1) && push_idx <= PW'(MAX_PAY)));

endmodule

// File: rtl/rf_frame_buffer.sv
// Frame exchange buffer: a shared request/answer store with a sequential
// host port. It runs the transmit, clear, wait and store sequence.
// Assumes tx_ready may stall at any time, and rx_done follows the last byte.
module rf_frame_buffer
    import rfb_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 100,
    parameter int unsigned BUF_BYTES  = 36
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_restart,
    input  logic       host_wr_en,
    input  logic [7:0] host_wr_data,
    input  logic       host_rd_en,
    output logic [7:0] host_rd_data,
    input  logic       start,
    input  logic [1:0] wdg_sel,
    output logic       busy,
    output logic       len_err,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_done
);
    localparam int unsigned MAX_PAY = BUF_BYTES - 1;
    localparam int unsigned PW      = $clog2(BUF_BYTES);
    localparam logic [PW-1:0] LAST  = PW'(MAX_PAY);

    rfb_state_t    state;
    logic [7:0]    mem [BUF_BYTES];
    logic [PW-1:0] ptr;
    logic [PW-1:0] idx;
    logic [15:0]   crc;
    logic [1:0]    sel_q;
    logic          bad_len;
    logic          wd_running;
    logic          wd_expired;
    logic          push_valid;
    logic [PW-1:0] push_idx;
    logic [7:0]    push_data;
    logic          ans_good;
    logic [7:0]    ans_len;
    logic          in_wait;
    logic          arm;

    assign bad_len      = (mem[0] == 8'h00) || (mem[0] > 8'(MAX_PAY));
    assign busy         = (state != ST_IDLE);
    assign in_wait      = (state == ST_WAIT);
    assign arm          = (state == ST_CLEAR);
    assign host_rd_data = mem[ptr];

    // Present payload bytes first, then the complemented CRC low and high.
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        case (state)
            ST_TX_DATA:   begin tx_valid = 1'b1; tx_data = mem[idx];   end
            ST_TX_CRC_LO: begin tx_valid = 1'b1; tx_data = ~crc[7:0];  end
            ST_TX_CRC_HI: begin tx_valid = 1'b1; tx_data = ~crc[15:8]; end
            default:      ;
        endcase
    end

    rfb_watchdog #(.CYC_PER_US(CYC_PER_US)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .stop    (in_wait && rx_done),
        .sel     (sel_q),
        .running (wd_running),
        .expired (wd_expired)
    );

    rfb_rx_stage #(.MAX_PAY(MAX_PAY), .PW(PW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (arm),
        .en         (in_wait),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .push_valid (push_valid),
        .push_idx   (push_idx),
        .push_data  (push_data),
        .ans_good   (ans_good),
        .ans_len    (ans_len)
    );

    // Sequence the exchange and own every write into the store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ptr     <= '0;
            idx     <= '0;
            crc     <= CRC_PRESET;
            sel_q   <= 2'b00;
            len_err <= 1'b0;
            for (int i = 0; i < BUF_BYTES; i++) begin
                mem[i] <= 8'h00;
            end
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (bad_len) begin
                            len_err <= 1'b1;
                        end else begin
                            len_err <= 1'b0;
                            idx     <= PW'(1);
                            crc     <= CRC_PRESET;
                            sel_q   <= wdg_sel;
                            state   <= ST_TX_DATA;
                        end
                    end else if (host_restart) begin
                        ptr <= '0;
                    end else begin
                        if (host_wr_en) begin
                            mem[ptr] <= host_wr_data;
                        end
                        if ((host_wr_en || host_rd_en) && ptr != LAST) begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                end
                ST_TX_DATA: begin
                    if (tx_ready) begin
                        crc <= crc16b_step(crc, mem[idx]);
                        if (8'(idx) == mem[0]) begin
                            state <= ST_TX_CRC_LO;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_TX_CRC_LO: begin
                    if (tx_ready) begin
                        state <= ST_TX_CRC_HI;
                    end
                end
                ST_TX_CRC_HI: begin
                    if (tx_ready) begin
                        state <= ST_CLEAR;
                    end
                end
                ST_CLEAR: begin
                    for (int i = 0; i < BUF_BYTES; i++) begin
                        mem[i] <= 8'h00;
                    end
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rx_done) begin
                        if (ans_good) begin
                            mem[0] <= ans_len;
                        end else begin
                            for (int i = 1; i < BUF_BYTES; i++) begin
                                mem[i] <= 8'h00;
                            end
                            mem[0] <= 8'hFF;
                        end
                        ptr   <= '0;
                        state <= ST_IDLE;
                    end else if (wd_expired) begin
                        for (int i = 0; i < BUF_BYTES; i++) begin
                            mem[i] <= 8'h00;
                        end
                        ptr   <= '0;
                        state <= ST_IDLE;
                    end else if (push_valid) begin
                        mem[push_idx] <= push_data;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: a stalled byte is held unchanged until taken
    a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R5: the store is empty on entry to the wait
    a_r5_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR) |=> (mem[0] == 8'h00 && mem[MAX_PAY] == 8'h00 && wd_running));
    // R9: a bad length never leaves idle and raises the flag
    a_r9_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && bad_len) |=> (!busy && len_err));
    // R10: the host pointer is frozen while the exchange is transmitting
    a_r10_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !in_wait) |=> $stable(ptr));

endmodule

// File: tb/rf_frame_buffer_bench.sv
`timescale 1ns/1ps
module rf_frame_buffer_bench;
    localparam int NB = 36;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_restart = 1'b0, host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [7:0] host_wr_data = 8'h00;
    logic [7:0] host_rd_data;
    logic       start = 1'b0;
    logic [1:0] wdg_sel = 2'b00;
    logic       busy, len_err, tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b1;
    logic       rx_valid = 1'b0, rx_done = 1'b0;
    logic [7:0] rx_data = 8'h00;

    int nchk = 0, nfail = 0;
    int txn = 0, busy_cyc = 0;
    logic [7:0] txcap [64];
    logic       stall_en = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    logic [7:0] exp_buf [NB];
    logic [7:0] got_buf [NB];

    always #2.5 clk = ~clk;

    rf_frame_buffer #(.CYC_PER_US(1)) u_rf_frame_buffer (
        .clk(clk), .rst_n(rst_n), .host_restart(host_restart), .host_wr_en(host_wr_en),
        .host_wr_data(host_wr_data), .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .start(start), .wdg_sel(wdg_sel), .busy(busy), .len_err(len_err),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_done(rx_done));

    // Record transmitted bytes and busy cycles with the values before each edge.
    always @(posedge clk) begin
        if (tx_valid && tx_ready) begin
            txcap[txn] <= tx_data;
            txn <= txn + 1;
        end
        if (busy) busy_cyc <= busy_cyc + 1;
    end

    // Stall pattern for the transmitter handshake.
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready = stall_en ? lfsr[0] : 1'b1;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_model(input logic [7:0] d [64], input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ d[i][b];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 7 + i * 13 + 1) & 255);
    endfunction

    task automatic restart();
        host_restart = 1'b1; @(negedge clk); host_restart = 1'b0;
    endtask

    task automatic wr(input logic [7:0] v);
        host_wr_en = 1'b1; host_wr_data = v; @(negedge clk); host_wr_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        v = host_rd_data; host_rd_en = 1'b1; @(negedge clk); host_rd_en = 1'b0;
    endtask

    task automatic read_all();
        restart();
        for (int i = 0; i < NB; i++) rd(got_buf[i]);
    endtask

    task automatic chk_buf(input string req);
        int bad = -1;
        read_all();
        for (int i = 0; i < NB; i++) if (bad < 0 && got_buf[i] != exp_buf[i]) bad = i;
        if (bad < 0) chk(req, 0, 0);
        else chk({req, " byte mismatch"}, int'(got_buf[bad]), int'(exp_buf[bad]));
    endtask

    task automatic load_frame(input int len, input int seed);
        restart();
        wr(8'(len));
        for (int i = 1; i <= len && i < NB; i++) wr(pat(seed, i));
    endtask

    task automatic fire(input logic [1:0] sel);
        txn = 0; busy_cyc = 0;
        start = 1'b1; wdg_sel = sel; @(negedge clk); start = 1'b0;
    endtask

    // Wait for payload plus CRC, check it, and step into the answer window.
    task automatic tx_phase(input int len, input int seed, input string req);
        logic [7:0] d [64];
        logic [15:0] c;
        int bad = -1;
        while (txn < len + 2) @(negedge clk);
        for (int i = 0; i < len; i++) d[i] = pat(seed, i + 1);
        c = ~crc_model(d, len);
        d[len] = c[7:0]; d[len + 1] = c[15:8];
        for (int i = 0; i < len + 2; i++) if (bad < 0 && txcap[i] != d[i]) bad = i;
        if (bad < 0) chk(req, 0, 0);
        else chk({req, " tx byte"}, int'(txcap[bad]), int'(d[bad]));
        @(negedge clk);
    endtask

    // Drive n data bytes and their CRC. mode 1 corrupts a byte; mode 2 drops one CRC byte.
    task automatic answer(input int n, input int seed, input int mode);
        logic [7:0] d [64];
        logic [15:0] c;
        int tot;
        for (int i = 0; i < n; i++) d[i] = pat(seed, i + 40);
        c = ~crc_model(d, n);
        d[n] = c[7:0]; d[n + 1] = c[15:8];
        if (mode == 1) d[0] = d[0] ^ 8'h10;
        tot = (mode == 2) ? n + 1 : n + 2;
        for (int i = 0; i < tot; i++) begin
            rx_valid = 1'b1; rx_data = d[i]; @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_done = 1'b1; @(negedge clk); rx_done = 1'b0;
        for (int i = 0; i < NB; i++) exp_buf[i] = 8'h00;
        if (mode == 0 && n >= 1 && n <= 35) begin
            exp_buf[0] = 8'(n);
            for (int i = 0; i < n; i++) exp_buf[i + 1] = pat(seed, i + 40);
        end else begin
            exp_buf[0] = 8'hFF;
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        nchk++; nfail++;
        $display("FAIL watchdog: run did not finish actual=1 expected=0");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 len_err", int'(len_err), 0);
        chk("R1 tx_valid", int'(tx_valid), 0);
        for (int i = 0; i < NB; i++) exp_buf[i] = 8'h00;
        chk_buf("R1 store zero");

        // R2 host write/read with pointer saturation
        restart();
        for (int i = 0; i < NB; i++) wr(pat(3, i));
        wr(8'hAA); wr(8'hAB);
        for (int i = 0; i < NB; i++) exp_buf[i] = pat(3, i);
        exp_buf[NB - 1] = 8'hAB;
        chk_buf("R2 roundtrip");
        rd(v);
        chk("R2 pointer holds at 35", int'(v), 32'hAB);

        // R3 R4 R5 R8 transmit then timeout, several lengths and stall patterns
        for (int k = 0; k < 4; k++) begin
            int len;
            len = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 7 : 35;
            stall_en = (k >= 2);
            load_frame(len, k);
            fire(2'b00);
            tx_phase(len, k, "R3 R4 payload and CRC");
            wait_idle();
            stall_en = 1'b0;
            if (k < 2) chk("R8 busy cycles sel00", busy_cyc, len + 3 + 500);
            for (int i = 0; i < NB; i++) exp_buf[i] = 8'h00;
            chk_buf("R5 R8 cleared after timeout");
        end

        // R6 good answers at length boundaries
        for (int k = 0; k < 3; k++) begin
            int n;
            n = (k == 0) ? 1 : (k == 1) ? 5 : 35;
            load_frame(3, 10 + k);
            fire(2'b00);
            tx_phase(3, 10 + k, "R3 short request");
            answer(n, k, 0);
            chk("R6 busy falls", int'(busy), 0);
            chk_buf("R6 stored answer");
        end

        // R7 malformed answers: corrupted, CRC only, one byte too long, truncated
        for (int k = 0; k < 4; k++) begin
            load_frame(4, 20 + k);
            fire(2'b00);
            tx_phase(4, 20 + k, "R4 request");
            case (k)
                0: answer(4, k, 1);
                1: answer(0, k, 0);
                2: answer(36, k, 0);
                default: answer(6, k, 2);
            endcase
            chk_buf("R7 error code FFh");
        end

        // R9 rejected lengths then recovery
        for (int k = 0; k < 3; k++) begin
            int len;
            len = (k == 0) ? 0 : (k == 1) ? 36 : 200;
            restart(); wr(8'(len));
            fire(2'b00);
            chk("R9 len_err set", int'(len_err), 1);
            chk("R9 busy stays low", int'(busy), 0);
            repeat (4) @(negedge clk);
            chk("R9 nothing sent", txn, 0);
        end
        load_frame(2, 30);
        fire(2'b00);
        chk("R9 len_err cleared", int'(len_err), 0);

        // R10 host traffic while busy is ignored
        tx_phase(2, 30, "R3 request");
        restart(); wr(8'h77); wr(8'h66); rd(v);
        answer(3, 9, 0);
        chk_buf("R10 host ignored while busy");
        // R10 receiver traffic while idle is ignored
        for (int i = 0; i < 4; i++) begin
            rx_valid = 1'b1; rx_data = 8'hC3; @(negedge clk);
        end
        rx_valid = 1'b0; rx_done = 1'b1; @(negedge clk); rx_done = 1'b0;
        chk_buf("R10 rx ignored while idle");

        // R8 longer timeouts
        load_frame(35, 40);
        fire(2'b01);
        tx_phase(35, 40, "R4 long request");
        wait_idle();
        chk("R8 busy cycles sel01", busy_cyc, 35 + 3 + 5000);
        load_frame(2, 41);
        fire(2'b10);
        tx_phase(2, 41, "R4 request");
        wait_idle();
        chk("R8 busy cycles sel10", busy_cyc, 2 + 3 + 10000);
        // R8 select 11 still waiting after the 10 ms window
        load_frame(1, 42);
        fire(2'b11);
        tx_phase(1, 42, "R4 request");
        repeat (10500) @(negedge clk);
        chk("R8 sel11 still busy", int'(busy), 1);
        answer(2, 5, 0);
        chk_buf("R8 R6 late answer accepted");

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule